// File: doc/BRIEF.md
# Handshaked Parallel Port

This block is a byte-wide, two-way parallel port with a handshake for each direction, intended for a microcomputer I/O card. On the outgoing side, a CPU write stores a byte on the output pins and sets an output-ready status flag. It also sends a one-clock strobe toward the attached device. The device empties the flag by pulsing its clear line.

On the incoming side, the attached device presents a byte together with a strobe. A two-bit configuration input decides how that strobe captures the byte:

- on its rising edge;
- on its falling edge;
- as a gate, where the held byte tracks the pins while the strobe is high and freezes when it drops;
- not at all.

Each capture sets an input-ready status flag and sends a one-clock accepted pulse back to the device. A CPU read of the input byte empties the input-ready flag.

The external strobe, clear and data lines are asynchronous. They pass through a two-flop synchroniser before any edge is detected. Line drivers, receivers and wiring options are not part of this block.

Top module: `hs_parport`

## Requirements
- R1: While `rst` is high at a clock edge, the flops after that edge read as follows: `out_ready`, `in_ready`, `out_stb` and `in_ack` are 0, and `pd_out` and `in_data` are all zeros.
- R2: At the clock edge where `cpu_wr_out` is 1, `pd_out` takes `cpu_wdata` and `out_ready` becomes 1. In the cycle after that edge, `out_stb` is high for exactly one clock.
- R3: A rising edge on `ext_clr` clears `out_ready` at the third clock edge after the change. Keeping `ext_clr` high does not clear it again. If a CPU write happens at the same edge as the clear, the write wins and `out_ready` stays 1.
- R4: With `cap_mode` = 2'b01, a rising edge on `ext_stb` has three effects at the third clock edge after it: `in_data` takes the value on `ext_din`, `in_ready` becomes 1, and `in_ack` becomes 1.
- R5: With `cap_mode` = 2'b10, the same capture happens on a falling edge of `ext_stb`, with the same three-edge latency.
- R6: With `cap_mode` = 2'b11, `in_data` follows `ext_din` with a three-edge latency while `ext_stb` is high, and holds its last value after `ext_stb` falls. `in_ready` and `in_ack` are set by the falling edge and not by the rising edge.
- R7: With `cap_mode` = 2'b00, strobe activity leaves `in_data` and `in_ready` unchanged and produces no `in_ack`.
- R8: `in_ack` is a one-clock pulse per capture. It is high in the first cycle in which `in_ready` is set by that capture.
- R9: A clock edge with `cpu_rd_in` high clears `in_ready`. A capture at the same edge wins, and `in_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_out | input | 1 | CPU write of the output byte |
| cpu_wdata | input | DATA_W | Byte written by the CPU |
| cpu_rd_in | input | 1 | CPU read of the input byte |
| cap_mode | input | 2 | Input strobe mode: 00 off, 01 rising, 10 falling, 11 gate |
| ext_clr | input | 1 | Asynchronous clear of output-ready, acting on its rising edge |
| ext_stb | input | 1 | Asynchronous input strobe |
| ext_din | input | DATA_W | Asynchronous input data |
| pd_out | output | DATA_W | Latched output byte |
| out_stb | output | 1 | One-clock output strobe |
| out_ready | output | 1 | Output-ready status |
| in_data | output | DATA_W | Captured input byte |
| in_ready | output | 1 | Input-ready status |
| in_ack | output | 1 | One-clock input-accepted pulse |

## Verification
A CPU write shows on `pd_out` and `out_ready` right after its own edge, and the strobe appears in the same sampled cycle. Every external event needs three edges to take effect: two synchroniser flops, then the registered result. The bench changes inputs on falling clock edges and samples at a falling edge, after a counted number of rising edges. It also samples one edge earlier, to show that nothing has happened before the due edge. For the same-cycle conflicts, the CPU strobe is driven high during exactly the third edge after the external change.

// File: rtl/hs_parport_pkg.sv
package hs_parport_pkg;
  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_GATE = 2'b11
  } cap_mode_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '0;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hs_out_chan.sv
module hs_out_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_s,
  output logic [DATA_W-1:0] pd,
  output logic              stb,
  output logic              ready
);
  logic clr_d;
  logic clr_rise;

  assign clr_rise = clr_s & ~clr_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_d <= 1'b0;
      pd    <= '0;
      stb   <= 1'b0;
      ready <= 1'b0;
    end else begin
      clr_d <= clr_s;
      stb   <= wr;
      if (wr) begin
        pd    <= wdata;
        ready <= 1'b1;
      end else if (clr_rise) begin
        ready <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hs_in_chan.sv
module hs_in_chan
  import hs_parport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              stb_s,
  input  logic [DATA_W-1:0] din_s,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              ready,
  output logic              ack
);
  cap_mode_e m;
  logic stb_d, rise, fall;
  logic evt, load;

  assign m    = cap_mode_e'(mode);
  assign rise = stb_s & ~stb_d;
  assign fall = ~stb_s & stb_d;

  always_comb begin
    evt  = 1'b0;
    load = 1'b0;
    case (m)
      CAP_RISE: begin evt = rise; load = rise;  end
      CAP_FALL: begin evt = fall; load = fall;  end
      CAP_GATE: begin evt = fall; load = stb_s; end
      default:  begin evt = 1'b0; load = 1'b0;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_d <= 1'b0;
      data  <= '0;
      ready <= 1'b0;
      ack   <= 1'b0;
    end else begin
      stb_d <= stb_s;
      ack   <= evt;
      if (load) data <= din_s;
      if (evt)     ready <= 1'b1;
      else if (rd) ready <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_parport.sv
module hs_parport #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_out,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd_in,
  input  logic [1:0]        cap_mode,
  input  logic              ext_clr,
  input  logic              ext_stb,
  input  logic [DATA_W-1:0] ext_din,
  output logic [DATA_W-1:0] pd_out,
  output logic              out_stb,
  output logic              out_ready,
  output logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              in_ack
);
  localparam int SW = DATA_W + 2;

  logic [SW-1:0]     sync_q;
  logic [DATA_W-1:0] din_s;
  logic              stb_s, clr_s;

  hs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_din, ext_stb, ext_clr}),
    .q   (sync_q)
  );

  assign din_s = sync_q[SW-1:2];
  assign stb_s = sync_q[1];
  assign clr_s = sync_q[0];

  hs_out_chan #(.DATA_W(DATA_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .wr    (cpu_wr_out),
    .wdata (cpu_wdata),
    .clr_s (clr_s),
    .pd    (pd_out),
    .stb   (out_stb),
    .ready (out_ready)
  );

  hs_in_chan #(.DATA_W(DATA_W)) u_in (
    .clk   (clk),
    .rst   (rst),
    .mode  (cap_mode),
    .stb_s (stb_s),
    .din_s (din_s),
    .rd    (cpu_rd_in),
    .data  (in_data),
    .ready (in_ready),
    .ack   (in_ack)
  );
endmodule

// File: rtl/hs_parport_chk.sv
module hs_parport_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr_out,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rd_in,
  input logic [1:0]        cap_mode,
  input logic [DATA_W-1:0] pd_out,
  input logic              out_stb,
  input logic              out_ready,
  input logic              in_ready,
  input logic              in_ack
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_ready && !in_ready && !out_stb && !in_ack));

  p_write_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_out |=> (out_ready && out_stb && pd_out == $past(cpu_wdata)));

  p_stb_cause_r2: assert property (@(posedge clk) disable iff (rst)
    out_stb |-> $past(cpu_wr_out));

  p_off_no_ack_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(cap_mode) == 2'b00) |-> !in_ack);

  p_ack_with_ready_r8: assert property (@(posedge clk) disable iff (rst)
    in_ack |-> in_ready);

  p_ready_rise_ack_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> in_ack);

  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_in |=> (!in_ready || in_ack));
endmodule

bind hs_parport hs_parport_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_wr_out (cpu_wr_out),
  .cpu_wdata  (cpu_wdata),
  .cpu_rd_in  (cpu_rd_in),
  .cap_mode   (cap_mode),
  .pd_out     (pd_out),
  .out_stb    (out_stb),
  .out_ready  (out_ready),
  .in_ready   (in_ready),
  .in_ack     (in_ack)
);

// File: tb/sim_hs_parport.sv
`timescale 1ns/1ps
module sim_hs_parport;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_wr_out = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_rd_in = 1'b0;
  logic [1:0]    cap_mode = 2'b00;
  logic          ext_clr = 1'b0;
  logic          ext_stb = 1'b0;
  logic [DW-1:0] ext_din = '0;
  logic [DW-1:0] pd_out, in_data;
  logic          out_stb, out_ready, in_ready, in_ack;

  int checks = 0;
  int failures = 0;
  int ack_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hs_parport #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .cpu_wr_out(cpu_wr_out), .cpu_wdata(cpu_wdata),
    .cpu_rd_in(cpu_rd_in), .cap_mode(cap_mode), .ext_clr(ext_clr),
    .ext_stb(ext_stb), .ext_din(ext_din), .pd_out(pd_out), .out_stb(out_stb),
    .out_ready(out_ready), .in_data(in_data), .in_ready(in_ready), .in_ack(in_ack)
  );

  always @(negedge clk) if (in_ack) ack_cnt++;

  // Output-side vectors: byte written, expected pd_out
  localparam logic [15:0] OUT_VEC [4] = '{16'h5A5A, 16'h0000, 16'hFFFF, 16'h8181};
  // Capture vectors: {mode, data}; mode 01 rising, 10 falling
  localparam logic [9:0] CAP_VEC [6] = '{
    {2'b01, 8'h3C}, {2'b10, 8'hC3}, {2'b01, 8'h00},
    {2'b10, 8'hFF}, {2'b01, 8'h96}, {2'b10, 8'h69}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk(!out_ready && !in_ready && !out_stb && !in_ack, "R1 flags",
        {out_ready, in_ready, out_stb, in_ack}, 0);
    chk(pd_out == 0 && in_data == 0, "R1 data", {pd_out, in_data}, 0);

    // R2 / R3 vector loop
    foreach (OUT_VEC[i]) begin
      cpu_wr_out = 1'b1; cpu_wdata = OUT_VEC[i][15:8];
      tick(1);
      cpu_wr_out = 1'b0;
      chk(pd_out == OUT_VEC[i][7:0], "R2 pd_out", pd_out, OUT_VEC[i][7:0]);
      chk(out_ready && out_stb, "R2 ready+stb", {out_ready, out_stb}, 2'b11);
      tick(1);
      chk(!out_stb, "R2 stb one cycle", out_stb, 0);
      ext_clr = 1'b1;
      tick(2);
      chk(out_ready, "R3 not yet cleared", out_ready, 1);
      tick(1);
      chk(!out_ready, "R3 cleared", out_ready, 0);
      ext_clr = 1'b0;
      tick(3);
    end

    // R3 write wins over clear in same cycle; level does not re-clear
    ext_clr = 1'b1;
    tick(2);
    cpu_wr_out = 1'b1; cpu_wdata = 8'h42;
    tick(1);
    cpu_wr_out = 1'b0;
    chk(out_ready, "R3 write wins", out_ready, 1);
    tick(4);
    chk(out_ready, "R3 held clear no effect", out_ready, 1);
    ext_clr = 1'b0;
    tick(3);
    ext_clr = 1'b1;
    tick(3);
    chk(!out_ready, "R3 second edge clears", out_ready, 0);
    ext_clr = 1'b0;
    tick(3);

    // R4 / R5 / R8 / R9 capture loop
    foreach (CAP_VEC[i]) begin
      automatic logic [1:0] md = CAP_VEC[i][9:8];
      automatic logic [7:0] dv = CAP_VEC[i][7:0];
      cap_mode = 2'b00;
      ext_stb = (md == 2'b10);
      tick(4);
      cap_mode = md;
      ext_din = dv;
      tick(2);
      ext_stb = ~ext_stb;
      tick(2);
      chk(!in_ack && !in_ready, "R4/R5 not before third edge",
          {in_ack, in_ready}, 0);
      tick(1);
      if (md == 2'b01) chk(in_data == dv && in_ready, "R4 rising capture", in_data, dv);
      else             chk(in_data == dv && in_ready, "R5 falling capture", in_data, dv);
      chk(in_ack, "R8 ack with capture", in_ack, 1);
      tick(1);
      chk(!in_ack && in_ready, "R8 ack one cycle", {in_ack, in_ready}, 2'b01);
      cpu_rd_in = 1'b1;
      tick(1);
      cpu_rd_in = 1'b0;
      chk(!in_ready, "R9 read clears", in_ready, 0);
    end

    // R6 gate mode
    cap_mode = 2'b00; ext_stb = 1'b0;
    tick(4);
    cap_mode = 2'b11;
    ext_din = 8'hA5; ext_stb = 1'b1;
    tick(3);
    chk(in_data == 8'hA5, "R6 follows while high", in_data, 8'hA5);
    chk(!in_ready && !in_ack, "R6 rising no ready", {in_ready, in_ack}, 0);
    ext_din = 8'h3C;
    tick(3);
    chk(in_data == 8'h3C, "R6 follows change", in_data, 8'h3C);
    ext_stb = 1'b0; ext_din = 8'hFF;
    tick(3);
    chk(in_data == 8'h3C, "R6 held after fall", in_data, 8'h3C);
    chk(in_ready && in_ack, "R6 ready on fall", {in_ready, in_ack}, 2'b11);
    tick(3);
    chk(in_data == 8'h3C, "R6 stays held", in_data, 8'h3C);

    // R7 disabled: ready still 1, data 3C
    cap_mode = 2'b00;
    begin
      automatic int a0 = ack_cnt;
      ext_din = 8'h11; ext_stb = 1'b1;
      tick(4);
      ext_stb = 1'b0;
      tick(4);
      chk(in_data == 8'h3C && in_ready, "R7 off keeps data", in_data, 8'h3C);
      chk(ack_cnt == a0, "R7 off no ack", ack_cnt - a0, 0);
    end
    cpu_rd_in = 1'b1;
    tick(1);
    cpu_rd_in = 1'b0;

    // R9 capture wins over simultaneous read
    cap_mode = 2'b01; ext_din = 8'h77;
    tick(4);
    ext_stb = 1'b1;
    tick(2);
    cpu_rd_in = 1'b1;
    tick(1);
    cpu_rd_in = 1'b0;
    chk(in_ready && in_data == 8'h77, "R9 capture wins", {in_ready, in_data}, 9'h177);
    tick(1);
    chk(in_ready, "R9 ready persists", in_ready, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule